// File: doc/BRIEF.md
# LCD Drive Polarity Inversion Controller

The block produces the drive polarity that keeps the liquid crystal DC-balanced. A field-rate base polarity flips on vertical strobes, either on every one (the default 2x rate) or on every second one (1x rate). The per-pixel polarity is derived from this base. Depending on a two-bit pattern code, it is combined with the parity of the current row, of the current column, of both, or of neither.

A line-level inversion signal goes out to the panel. It carries the polarity of the first pixel of the current line. It is reloaded only at a fixed number of clock cycles after each horizontal strobe. This keeps it stable across the horizontal edge, both before it and after it. Strobes are single-cycle pulses in the block's clock domain. The line period is assumed to be longer than the hold delay plus the required setup margin.

Top module: `lcd_pol_ctrl`

## Requirements
- R1: With `inv_mode` = 2'b00 (frame), `px_pol` equals the base polarity and does not change on row or pixel strobes.
- R2: With `rate_1x` low, every `vs_stb` inverts the base polarity. The change is visible on `px_pol` in the cycle after the strobe.
- R3: With `rate_1x` high, the base polarity inverts only on every second `vs_stb`. The first inversion after reset comes on the second strobe.
- R4: With `inv_mode` = 2'b11 (row), `px_pol` is the base XOR the row parity. Row parity is 0 for the first line that starts after a `vs_stb` and toggles on each later `hs_stb`. Pixel strobes have no effect.
- R5: With `inv_mode` = 2'b10 (column), `px_pol` is the base XOR the column parity. Column parity is cleared by `hs_stb`, is 0 for the first `px_stb` of the line, and toggles on each later `px_stb`.
- R6: With `inv_mode` = 2'b01 (pixel), `px_pol` is the base XOR the row parity XOR the column parity.
- R7: `inv_line` is loaded with the base polarity, XORed with the row parity in row and pixel modes only. The load happens exactly HOLD_CYC clock cycles after an `hs_stb` and at no other time.
- R8: When the line period is at least HOLD_CYC plus SETUP_CYC cycles, `inv_line` is unchanged for at least SETUP_CYC cycles before each `hs_stb`.
- R9: Synchronous active-low reset clears the base polarity, the row and column parity and `inv_line`, so both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inv_mode | input | 2 | Pattern: 00 frame, 01 pixel, 10 column, 11 row |
| rate_1x | input | 1 | High: base flips every second vertical strobe |
| vs_stb | input | 1 | Vertical strobe, one cycle per field |
| hs_stb | input | 1 | Horizontal strobe, one cycle per line |
| px_stb | input | 1 | Pixel strobe, one cycle per pixel |
| inv_line | output | 1 | Registered line-level inversion signal |
| px_pol | output | 1 | Polarity of the current pixel |

## Verification
The bench targets the off-by-one points of each counter. In 1x rate it checks that the first vertical strobe after reset leaves the polarity alone; a design that divides with the wrong phase would flip early. It checks that the first line after a field start and the first pixel after a line start both read parity 0; a tracker that toggles on the first strobe would invert the whole pattern. It samples `inv_line` one cycle before and exactly at the hold delay after a horizontal strobe; a loader that is off by one cycle, or one that follows the row parity at once, would change inside the hold window. It also checks that column mode leaves the row term out of `inv_line`.

// File: rtl/lcd_pol_pkg.sv
// Shared types for the polarity inversion controller.
// Assumes the two-bit pattern code is fixed by the panel interface.
package lcd_pol_pkg;

    typedef enum logic [1:0] {
        PM_FRAME  = 2'b00,
        PM_PIXEL  = 2'b01,
        PM_COLUMN = 2'b10,
        PM_ROW    = 2'b11
    } pol_mode_e;

    // True when the pattern alternates from row to row.
    function automatic logic mode_uses_row(pol_mode_e m);
        return (m == PM_ROW) || (m == PM_PIXEL);
    endfunction

    // True when the pattern alternates from column to column.
    function automatic logic mode_uses_col(pol_mode_e m);
        return (m == PM_COLUMN) || (m == PM_PIXEL);
    endfunction

endpackage

// File: rtl/lcd_pol_field.sv
// Field-rate base polarity generator.
// Flips on every vertical strobe (2x) or on every second one (1x).
// Assumes vs_stb is a single-cycle pulse.
module lcd_pol_field (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_1x,
    input  logic vs_stb,
    output logic base_pol
);

    logic base_q;
    logic skip_q;   // 1x phase: set after the strobe that did not flip

    // Advance the base polarity on each vertical strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= 1'b0;
            skip_q <= 1'b0;
        end else if (vs_stb) begin
            if (!rate_1x) begin
                base_q <= ~base_q;
                skip_q <= 1'b0;
            end else begin
                if (skip_q) begin
                    base_q <= ~base_q;
                end
                skip_q <= ~skip_q;
            end
        end
    end

    assign base_pol = base_q;

endmodule

// File: rtl/lcd_pol_parity.sv
// Position parity tracker for rows or columns.
// After clr_stb the next adv_stb marks position 0. Each later adv_stb
// toggles the parity. A clear has priority over an advance in the same cycle.
module lcd_pol_parity (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_stb,
    input  logic adv_stb,
    output logic parity
);

    logic par_q;
    logic fresh_q;  // no position has started since the last clear

    // Track the parity of the current position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q   <= 1'b0;
            fresh_q <= 1'b1;
        end else if (clr_stb) begin
            par_q   <= 1'b0;
            fresh_q <= 1'b1;
        end else if (adv_stb) begin
            if (fresh_q) begin
                fresh_q <= 1'b0;
            end else begin
                par_q <= ~par_q;
            end
        end
    end

    assign parity = par_q;

endmodule

// File: rtl/lcd_pol_inv_win.sv
// Line-level inversion register with a hold window.
// Reloads from line_pol exactly HOLD_CYC cycles after hs_stb and holds it
// otherwise. Assumes HOLD_CYC >= 1.
module lcd_pol_inv_win #(
    parameter int HOLD_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_stb,
    input  logic line_pol,
    output logic inv_q
);

    localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          inv_r;

    // Count out the hold window, then load the new line polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            inv_r  <= 1'b0;
        end else if (hs_stb) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                inv_r  <= line_pol;
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign inv_q = inv_r;

endmodule

// File: rtl/lcd_pol_ctrl.sv
// Top of the polarity inversion controller.
// Combines the field base polarity with the row and column parity according
// to the selected pattern. Drives the per-pixel polarity and the windowed
// line-level signal. All strobes are single-cycle pulses in the clk domain.
module lcd_pol_ctrl #(
    parameter int HOLD_CYC = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] inv_mode,
    input  logic       rate_1x,
    input  logic       vs_stb,
    input  logic       hs_stb,
    input  logic       px_stb,
    output logic       inv_line,
    output logic       px_pol
);
    import lcd_pol_pkg::*;

    localparam int NPAR = 2;    // index 0 rows, index 1 columns

    pol_mode_e       mode;
    logic            base_pol;
    logic [NPAR-1:0] clr_v;
    logic [NPAR-1:0] adv_v;
    logic [NPAR-1:0] par_v;
    logic            row_term;
    logic            col_term;
    logic            line_pol;

    assign mode  = pol_mode_e'(inv_mode);
    assign clr_v = {hs_stb, vs_stb};
    assign adv_v = {px_stb, hs_stb};

    lcd_pol_field u_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_1x  (rate_1x),
        .vs_stb   (vs_stb),
        .base_pol (base_pol)
    );

    for (genvar i = 0; i < NPAR; i++) begin : g_par
        lcd_pol_parity u_par (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_stb (clr_v[i]),
            .adv_stb (adv_v[i]),
            .parity  (par_v[i])
        );
    end

    // Select the parity terms that the current pattern uses.
    always_comb begin
        row_term = mode_uses_row(mode) & par_v[0];
        col_term = mode_uses_col(mode) & par_v[1];
        line_pol = base_pol ^ row_term;
        px_pol   = line_pol ^ col_term;
    end

    lcd_pol_inv_win #(.HOLD_CYC(HOLD_CYC)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_stb   (hs_stb),
        .line_pol (line_pol),
        .inv_q    (inv_line)
    );

endmodule

// File: rtl/lcd_pol_ctrl_chk.sv
// Property checker for lcd_pol_ctrl, attached through bind.
// Watches only the top-level ports.
module lcd_pol_ctrl_chk #(
    parameter int HOLD_CYC  = 60,
    parameter int SETUP_CYC = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] inv_mode,
    input logic       rate_1x,
    input logic       vs_stb,
    input logic       hs_stb,
    input logic       px_stb,
    input logic       inv_line,
    input logic       px_pol
);

    localparam int HW = $clog2(HOLD_CYC + 2) + 1;
    localparam int SW = $clog2(SETUP_CYC + 1) + 1;
    localparam logic [HW-1:0] H_SAT = HW'(HOLD_CYC + 1);
    localparam logic [HW-1:0] H_EXP = HW'(HOLD_CYC);
    localparam logic [SW-1:0] S_SAT = SW'(SETUP_CYC);

    logic [HW-1:0] hs_age;
    logic [SW-1:0] chg_age;
    logic          prev_inv;

    // Age of the last horizontal strobe and of the last inv_line change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_age   <= H_SAT;
            chg_age  <= S_SAT;
            prev_inv <= 1'b0;
        end else begin
            prev_inv <= inv_line;
            if (hs_stb)
                hs_age <= '0;
            else if (hs_age != H_SAT)
                hs_age <= hs_age + 1'b1;
            if (inv_line != prev_inv)
                chg_age <= SW'(1);
            else if (chg_age != S_SAT)
                chg_age <= chg_age + 1'b1;
        end
    end

    // R9: outputs are cleared by reset
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!inv_line && !px_pol));

    // R1: frame pattern ignores row and pixel strobes
    a_r1_frame_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_mode == 2'b00 && $past(inv_mode) == 2'b00 && $past(rst_n)
         && !$past(vs_stb)) |-> $stable(px_pol));

    // R2: in 2x rate every vertical strobe inverts the frame polarity
    a_r2_vs_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vs_stb) && !$past(rate_1x) && $past(rst_n)
         && inv_mode == 2'b00 && $past(inv_mode) == 2'b00)
        |-> (px_pol != $past(px_pol)));

    // R4: row pattern holds within a line
    a_r4_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_mode == 2'b11 && $past(inv_mode) == 2'b11 && $past(rst_n)
         && !$past(vs_stb) && !$past(hs_stb)) |-> $stable(px_pol));

    // R5: column pattern changes only on strobes
    a_r5_col_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_mode == 2'b10 && $past(inv_mode) == 2'b10 && $past(rst_n)
         && !$past(vs_stb) && !$past(hs_stb) && !$past(px_stb))
        |-> $stable(px_pol));

    // R7: inv_line moves only at the end of the hold window
    a_r7_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_line != prev_inv) |-> (hs_age == H_EXP));

    // R8: inv_line has been steady for the setup margin at each strobe
    a_r8_setup_margin: assert property (@(posedge clk) disable iff (!rst_n)
        hs_stb |-> (inv_line == prev_inv && chg_age >= S_SAT));

endmodule

bind lcd_pol_ctrl lcd_pol_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_mode (inv_mode),
    .rate_1x  (rate_1x),
    .vs_stb   (vs_stb),
    .hs_stb   (hs_stb),
    .px_stb   (px_stb),
    .inv_line (inv_line),
    .px_pol   (px_pol)
);

// File: tb/lcd_pol_ctrl_test.sv
// Directed bench for lcd_pol_ctrl. Each task runs one scenario and checks it.
module lcd_pol_ctrl_test;

    localparam int HOLD = 60;
    localparam int LINE = 140;  // idle cycles after each horizontal strobe

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] inv_mode = 2'b00;
    logic       rate_1x = 1'b0;
    logic       vs_stb = 1'b0;
    logic       hs_stb = 1'b0;
    logic       px_stb = 1'b0;
    logic       inv_line;
    logic       px_pol;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lcd_pol_ctrl #(.HOLD_CYC(HOLD)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_mode (inv_mode),
        .rate_1x  (rate_1x),
        .vs_stb   (vs_stb),
        .hs_stb   (hs_stb),
        .px_stb   (px_stb),
        .inv_line (inv_line),
        .px_pol   (px_pol)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic r1x);
        @(negedge clk);
        rst_n = 1'b0; inv_mode = m; rate_1x = r1x;
        vs_stb = 1'b0; hs_stb = 1'b0; px_stb = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_vs();
        vs_stb = 1'b1; @(negedge clk); vs_stb = 1'b0; idle(2);
    endtask

    task automatic pulse_hs();
        hs_stb = 1'b1; @(negedge clk); hs_stb = 1'b0;
    endtask

    task automatic pulse_px();
        px_stb = 1'b1; @(negedge clk); px_stb = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2'b00, 1'b0);
        chk("R9 px_pol after reset", px_pol, 1'b0);
        chk("R9 inv_line after reset", inv_line, 1'b0);
        pulse_vs();
        pulse_hs(); idle(LINE);
        chk("R9 inv_line set before reset", inv_line, 1'b1);
        do_reset(2'b00, 1'b0);
        chk("R9 px_pol cleared", px_pol, 1'b0);
        chk("R9 inv_line cleared", inv_line, 1'b0);
    endtask

    task automatic t_frame_2x();
        do_reset(2'b00, 1'b0);
        pulse_hs();
        pulse_px(); chk("R1 frame px0", px_pol, 1'b0);
        pulse_px(); chk("R1 frame px1", px_pol, 1'b0);
        idle(LINE);
        pulse_hs(); pulse_px(); chk("R1 frame line1", px_pol, 1'b0);
        idle(LINE);
        pulse_vs(); chk("R2 first vs", px_pol, 1'b1);
        pulse_vs(); chk("R2 second vs", px_pol, 1'b0);
        pulse_vs(); chk("R2 third vs", px_pol, 1'b1);
    endtask

    task automatic t_rate_1x();
        do_reset(2'b00, 1'b1);
        pulse_vs(); chk("R3 vs1 no flip", px_pol, 1'b0);
        pulse_vs(); chk("R3 vs2 flip", px_pol, 1'b1);
        pulse_vs(); chk("R3 vs3 no flip", px_pol, 1'b1);
        pulse_vs(); chk("R3 vs4 flip", px_pol, 1'b0);
    endtask

    task automatic t_row();
        do_reset(2'b11, 1'b0);
        pulse_vs();                         // base 1
        pulse_hs(); chk("R4 row0", px_pol, 1'b1);
        pulse_px(); pulse_px(); chk("R4 row0 pixels ignored", px_pol, 1'b1);
        idle(LINE);
        pulse_hs(); chk("R4 row1", px_pol, 1'b0);
        idle(LINE);
        pulse_hs(); chk("R4 row2", px_pol, 1'b1);
        idle(LINE);
        pulse_vs(); chk("R4 vs clears row, base 0", px_pol, 1'b0);
        pulse_hs(); chk("R4 first row after vs", px_pol, 1'b0);
        idle(LINE);
    endtask

    task automatic t_col();
        do_reset(2'b10, 1'b0);
        pulse_hs();
        pulse_px(); chk("R5 col0", px_pol, 1'b0);
        pulse_px(); chk("R5 col1", px_pol, 1'b1);
        pulse_px(); chk("R5 col2", px_pol, 1'b0);
        pulse_px(); chk("R5 col3", px_pol, 1'b1);
        idle(LINE);
        pulse_hs(); chk("R5 hs clears col", px_pol, 1'b0);
        pulse_px(); chk("R5 col0 next line", px_pol, 1'b0);
        idle(LINE);
    endtask

    task automatic t_pixel();
        do_reset(2'b01, 1'b0);
        pulse_hs();
        pulse_px(); chk("R6 r0c0", px_pol, 1'b0);
        pulse_px(); chk("R6 r0c1", px_pol, 1'b1);
        idle(LINE);
        pulse_hs();
        pulse_px(); chk("R6 r1c0", px_pol, 1'b1);
        pulse_px(); chk("R6 r1c1", px_pol, 1'b0);
        pulse_px(); chk("R6 r1c2", px_pol, 1'b1);
        idle(LINE);
    endtask

    task automatic t_inv();
        do_reset(2'b11, 1'b0);
        pulse_vs();                         // base 1, row 0 -> line pol 1
        chk("R7 vs alone leaves inv_line", inv_line, 1'b0);
        pulse_hs();
        idle(HOLD - 1); chk("R7 before hold end", inv_line, 1'b0);
        idle(1);        chk("R7 at hold end", inv_line, 1'b1);
        idle(LINE - HOLD);
        chk("R8 steady at next hs", inv_line, 1'b1);
        pulse_hs();                         // row 1 -> line pol 0
        chk("R7 hold after hs", inv_line, 1'b1);
        idle(HOLD - 1); chk("R7 row1 before hold end", inv_line, 1'b1);
        idle(1);        chk("R7 row1 at hold end", inv_line, 1'b0);
        idle(LINE);
        do_reset(2'b10, 1'b0);
        pulse_vs();
        pulse_hs(); idle(LINE);
        chk("R7 column mode line0", inv_line, 1'b1);
        pulse_hs(); idle(LINE);
        chk("R7 column mode no row term", inv_line, 1'b1);
    endtask

    initial begin
        t_reset();
        t_frame_2x();
        t_rate_1x();
        t_row();
        t_col();
        t_pixel();
        t_inv();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL all: watchdog expired, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule